// File: doc/BRIEF.md
# TDM Channel Slot Serializer

This block carries one audio channel through a time-division multiplexed serial frame, sending and receiving at the same time. The surrounding port supplies a one-cycle bit strobe for each serial clock period and a frame-start marker that coincides with the strobe of the frame's first bit. Within that frame, the channel's slot begins at a bit index equal to a 3-bit start delay plus a per-channel location offset. The slot is 8, 16, 24 or 32 bits long. Data is sent and received MSB first.

On the transmit side, a sample is taken from a valid/ready stream at the first bit of the slot. On the receive side, the captured word is delivered left-justified on a valid/ready stream. A port flagged as limited to 24 bits sends zeros in place of the 8 least significant bits and clears them on receive. A slot that would run past the programmed frame length is cut at the frame boundary, and a status pulse reports the cut.

Back-pressure rules. The transmit side never waits. `s_ready` is high only in the strobe cycle that opens the slot, and the sample is taken in that cycle only if `s_valid` is high. If `s_valid` is low then, the slot carries zeros. The receive side holds `m_valid` and `m_data` until `m_ready` is seen. A word that completes while an earlier word is still unread replaces the earlier word.

Top module: `tdm_slot_serializer`

## Requirements
- R1: Bit index 0 is the strobe cycle carrying `frame_start`. The slot's first bit is at index `start` = delay + `cfg_loc`. `sd_oe` is high for exactly 8×(`cfg_size`+1) bit periods from `start`: `cfg_size` 0 gives 8 bits, 1 gives 16, 2 gives 24 and 3 gives 32. Outside the slot `sd_oe` is low.
- R2: Delay codes 6 and 7 place the slot exactly as code 5 does.
- R3: Transmitted data is MSB first: slot bit k carries `s_data[31-k]`. `sd_out` and `sd_oe` change only in the cycle after a strobe. `sd_out` is low whenever `sd_oe` is low.
- R4: `s_ready` is high only in the strobe cycle of the slot's first bit, once per frame. If `s_valid` is low in that cycle, the whole slot carries zeros.
- R5: With `cfg_limit24` high, slot bits 24 to 31 are sent as zeros.
- R6: The receiver samples `sd_in` in each slot strobe cycle and places slot bit k at `m_data[31-k]`; bits beyond the slot are zero. `m_valid` rises in the cycle after the strobe of the last slot bit.
- R7: With `cfg_limit24` high, `m_data[7:0]` is zero.
- R8: `m_valid` stays high until `m_ready` is high. It clears in the cycle after the handshake. A newer word replaces an unread one.
- R9: A slot passing index `cfg_frame_len`-1 stops at that index. `slot_cut` pulses for one cycle after that strobe, and the partial word is delivered.
- R10: After reset, `sd_out`, `sd_oe`, `m_valid` and `slot_cut` are low. No slot occurs before the first `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| frame_start | input | 1 | Marks bit index 0; only valid together with bit_tick |
| cfg_fsd | input | 3 | Frame-start delay in bit periods (6 and 7 act as 5) |
| cfg_loc | input | LOC_W | Channel location offset in bit periods |
| cfg_size | input | 2 | Slot size code: 8×(code+1) bits |
| cfg_limit24 | input | 1 | Port limited to 24-bit resolution |
| cfg_frame_len | input | POS_W | Frame length in bit periods |
| s_valid | input | 1 | Transmit sample valid |
| s_ready | output | 1 | Transmit sample taken (slot first bit) |
| s_data | input | 32 | Transmit sample, left-justified |
| sd_out | output | 1 | Serial data out |
| sd_oe | output | 1 | Serial output enable, high during the slot |
| sd_in | input | 1 | Serial data in |
| m_valid | output | 1 | Received word valid |
| m_ready | input | 1 | Received word accepted |
| m_data | output | 32 | Received word, left-justified |
| slot_cut | output | 1 | Pulse: slot was truncated at frame end |

## Verification
Some properties are checked on every cycle:
- the enable and data lines stay quiet outside the slot and move only after a strobe;
- `s_ready` appears only with a strobe;
- a pending received word is held until accepted;
- the truncation pulse follows a strobe;
- each newly delivered word from a 24-bit-limited port has clear low bits.

Slot placement, length, MSB-first ordering, delay clamping, truncation length and the bit-exact words in both directions depend on the configuration. Only the bench's frame scenarios can show these, by comparing against words and positions computed from the requirements.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
  localparam int SAMPLE_W  = 32;
  localparam int OFF_W     = $clog2(SAMPLE_W);
  localparam int LIMIT_LSB = 8;
  localparam logic [2:0] FSD_MAX = 3'd5;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_24 = 2'd2,
    SZ_32 = 2'd3
  } slot_size_e;

  function automatic logic [6:0] slot_bits(slot_size_e s);
    return (7'({5'b0, s}) + 7'd1) << 3;
  endfunction

  function automatic logic [2:0] clamp_fsd(logic [2:0] code);
    return (code > FSD_MAX) ? FSD_MAX : code;
  endfunction
endpackage

// File: rtl/tdm_bit_counter.sv
module tdm_bit_counter #(
  parameter int POS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             frame_start,
  output logic [POS_W-1:0] cur_pos
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic [POS_W-1:0] pos_q;

  always_comb begin
    if (frame_start)         cur_pos = '0;
    else if (pos_q == POS_MAX) cur_pos = POS_MAX;
    else                     cur_pos = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pos_q <= POS_MAX;
    else if (bit_tick) pos_q <= cur_pos;
  end
endmodule

// File: rtl/tdm_slot_window.sv
module tdm_slot_window
  import tdm_slot_pkg::*;
#(
  parameter int POS_W = 10,
  parameter int LOC_W = 8
) (
  input  logic             bit_tick,
  input  logic [POS_W-1:0] cur_pos,
  input  logic [2:0]       cfg_fsd,
  input  logic [LOC_W-1:0] cfg_loc,
  input  logic [1:0]       cfg_size,
  input  logic [POS_W-1:0] cfg_frame_len,
  output logic             in_slot,
  output logic             first_bit,
  output logic             last_bit,
  output logic             cut,
  output logic [OFF_W-1:0] offset
);
  localparam int EXT_W = ((POS_W > LOC_W) ? POS_W : LOC_W) + 2;

  logic [EXT_W-1:0] start_x, end_x, cur_x, flen_x;
  logic in_range, natural_end, frame_end;

  always_comb begin
    start_x     = EXT_W'(clamp_fsd(cfg_fsd)) + EXT_W'(cfg_loc);
    end_x       = start_x + EXT_W'(slot_bits(slot_size_e'(cfg_size)));
    cur_x       = EXT_W'(cur_pos);
    flen_x      = EXT_W'(cfg_frame_len);
    in_range    = (cur_x >= start_x) && (cur_x < end_x) && (cur_x < flen_x);
    natural_end = (cur_x == end_x - 1'b1);
    frame_end   = (flen_x != '0) && (cur_x == flen_x - 1'b1);
    in_slot     = bit_tick && in_range;
    first_bit   = in_slot && (cur_x == start_x);
    last_bit    = in_slot && (natural_end || frame_end);
    cut         = in_slot && frame_end && !natural_end;
    offset      = OFF_W'(cur_x - start_x);
  end
endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
  import tdm_slot_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  logic                in_slot,
  input  logic                first_bit,
  input  logic [OFF_W-1:0]    offset,
  input  logic                cfg_limit24,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                s_ready,
  output logic                sd_out,
  output logic                sd_oe
);
  localparam logic [OFF_W-1:0] TOP_IDX  = OFF_W'(SAMPLE_W - 1);
  localparam logic [OFF_W-1:0] KEEP_LIM = OFF_W'(SAMPLE_W - LIMIT_LSB);

  logic [SAMPLE_W-1:0] held_q, word_src;
  logic                bit_val;

  assign s_ready = first_bit;

  always_comb begin
    if (first_bit) word_src = s_valid ? s_data : '0;
    else           word_src = held_q;
    bit_val = word_src[TOP_IDX - offset];
    if (cfg_limit24 && (offset >= KEEP_LIM)) bit_val = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      sd_out <= 1'b0;
      sd_oe  <= 1'b0;
    end else if (bit_tick) begin
      sd_oe  <= in_slot;
      sd_out <= in_slot & bit_val;
      if (first_bit) held_q <= word_src;
    end
  end
endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
  import tdm_slot_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_slot,
  input  logic                first_bit,
  input  logic                last_bit,
  input  logic [OFF_W-1:0]    offset,
  input  logic                sd_in,
  input  logic                cfg_limit24,
  input  logic                m_ready,
  output logic                m_valid,
  output logic [SAMPLE_W-1:0] m_data
);
  localparam logic [OFF_W-1:0]    TOP_IDX  = OFF_W'(SAMPLE_W - 1);
  localparam logic [SAMPLE_W-1:0] LSB_MASK = {{(SAMPLE_W-LIMIT_LSB){1'b1}}, {LIMIT_LSB{1'b0}}};

  logic [SAMPLE_W-1:0] acc_q, acc_next, word_out;

  always_comb begin
    acc_next = first_bit ? '0 : acc_q;
    acc_next[TOP_IDX - offset] = sd_in;
    word_out = cfg_limit24 ? (acc_next & LSB_MASK) : acc_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      m_data  <= '0;
      m_valid <= 1'b0;
    end else begin
      if (in_slot) acc_q <= acc_next;
      if (last_bit) begin
        m_data  <= word_out;
        m_valid <= 1'b1;
      end else if (m_valid && m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tdm_slot_serializer.sv
module tdm_slot_serializer
  import tdm_slot_pkg::*;
#(
  parameter int POS_W = 10,
  parameter int LOC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             frame_start,
  input  logic [2:0]       cfg_fsd,
  input  logic [LOC_W-1:0] cfg_loc,
  input  logic [1:0]       cfg_size,
  input  logic             cfg_limit24,
  input  logic [POS_W-1:0] cfg_frame_len,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [31:0]      s_data,
  output logic             sd_out,
  output logic             sd_oe,
  input  logic             sd_in,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [31:0]      m_data,
  output logic             slot_cut
);
  logic [POS_W-1:0] cur_pos;
  logic             in_slot, first_bit, last_bit, cut;
  logic [OFF_W-1:0] offset;

  tdm_bit_counter #(.POS_W(POS_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .frame_start(frame_start), .cur_pos(cur_pos)
  );

  tdm_slot_window #(.POS_W(POS_W), .LOC_W(LOC_W)) u_win (
    .bit_tick(bit_tick), .cur_pos(cur_pos), .cfg_fsd(cfg_fsd),
    .cfg_loc(cfg_loc), .cfg_size(cfg_size), .cfg_frame_len(cfg_frame_len),
    .in_slot(in_slot), .first_bit(first_bit), .last_bit(last_bit),
    .cut(cut), .offset(offset)
  );

  tdm_slot_tx u_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .in_slot(in_slot),
    .first_bit(first_bit), .offset(offset), .cfg_limit24(cfg_limit24),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .sd_out(sd_out), .sd_oe(sd_oe)
  );

  tdm_slot_rx u_rx (
    .clk(clk), .rst_n(rst_n), .in_slot(in_slot), .first_bit(first_bit),
    .last_bit(last_bit), .offset(offset), .sd_in(sd_in),
    .cfg_limit24(cfg_limit24), .m_ready(m_ready),
    .m_valid(m_valid), .m_data(m_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_cut <= 1'b0;
    else        slot_cut <= cut;
  end
endmodule

// File: rtl/tdm_slot_checker.sv
module tdm_slot_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bit_tick,
  input logic        cfg_limit24,
  input logic        s_ready,
  input logic        sd_out,
  input logic        sd_oe,
  input logic        m_valid,
  input logic        m_ready,
  input logic [31:0] m_data,
  input logic        slot_cut
);
  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_oe |-> !sd_out); // R3
  AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> ($stable(sd_oe) && $stable(sd_out))); // R3
  AST_READY_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> bit_tick); // R4
  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid); // R8
  AST_LIMIT_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(m_valid) && cfg_limit24) |-> (m_data[7:0] == 8'h00)); // R7
  AST_CUT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    slot_cut |-> $past(bit_tick)); // R9
endmodule

bind tdm_slot_serializer tdm_slot_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cfg_limit24(cfg_limit24),
  .s_ready(s_ready), .sd_out(sd_out), .sd_oe(sd_oe), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .slot_cut(slot_cut)
);

// File: tb/tb_tdm_slot_serializer.sv
module tb_tdm_slot_serializer;
  localparam int POS_W = 10;
  localparam int LOC_W = 8;

  typedef struct packed {
    logic [2:0]  fsd;
    logic [7:0]  loc;
    logic [1:0]  size;
    logic        lim;
    logic [9:0]  flen;
    logic [31:0] tx;
    logic [31:0] rx;
    logic        txv;
  } vec_t;

  localparam logic [88:0] VECS [8] = '{
    {3'd0, 8'd0,  2'd3, 1'b0, 10'd64, 32'hA5C30F1E, 32'h12345678, 1'b1},
    {3'd1, 8'd3,  2'd0, 1'b0, 10'd32, 32'h800000FF, 32'hDEADBEEF, 1'b1},
    {3'd5, 8'd10, 2'd2, 1'b1, 10'd64, 32'hFFFFFFFF, 32'h0F0F0F0F, 1'b1},
    {3'd2, 8'd4,  2'd3, 1'b1, 10'd64, 32'hCAFEBABE, 32'h13579BDF, 1'b1},
    {3'd7, 8'd0,  2'd1, 1'b0, 10'd40, 32'h1234ABCD, 32'h8421F00F, 1'b1},
    {3'd6, 8'd2,  2'd3, 1'b0, 10'd20, 32'hF00DFACE, 32'hBADC0FFE, 1'b1},
    {3'd3, 8'd50, 2'd3, 1'b1, 10'd70, 32'h5A5A5A5A, 32'hFFFFFFFF, 1'b1},
    {3'd4, 8'd1,  2'd3, 1'b0, 10'd37, 32'h0123ABCD, 32'h76543210, 1'b1}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n, bit_tick, frame_start, cfg_limit24, s_valid, s_ready;
  logic [2:0]       cfg_fsd;
  logic [LOC_W-1:0] cfg_loc;
  logic [1:0]       cfg_size;
  logic [POS_W-1:0] cfg_frame_len;
  logic [31:0]      s_data, m_data;
  logic             sd_out, sd_oe, sd_in, m_valid, m_ready, slot_cut;

  int n_tests = 0;
  int n_fail  = 0;

  tdm_slot_serializer #(.POS_W(POS_W), .LOC_W(LOC_W)) dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_start(frame_start),
    .cfg_fsd(cfg_fsd), .cfg_loc(cfg_loc), .cfg_size(cfg_size),
    .cfg_limit24(cfg_limit24), .cfg_frame_len(cfg_frame_len),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .slot_cut(slot_cut)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(int fsd, int loc, int size, bit lim, int flen,
                           logic [31:0] tx, logic [31:0] rx, bit txv, bit ack);
    int start, len, endp, eff, last_idx, oe_cnt, first_oe, rdy_cnt, rdy_idx;
    int mv_idx, cut_cnt, stable_err;
    bit cut, pending, mv_prev, oe_a, out_a;
    logic [31:0] mask, exp_tx, exp_rx, got_tx;
    start = ((fsd > 5) ? 5 : fsd) + loc;
    len   = 8 * (size + 1);
    endp  = start + len;
    eff   = (start >= flen) ? 0 : (((endp > flen) ? flen : endp) - start);
    cut   = (start < flen) && (endp > flen);
    last_idx = start + eff - 1;
    mask  = (eff == 0) ? 32'h0 : (32'hFFFFFFFF << (32 - eff));
    if (lim) mask &= 32'hFFFFFF00;
    exp_tx = (txv ? tx : 32'h0) & mask;
    exp_rx = rx & mask;
    oe_cnt = 0; first_oe = -1; rdy_cnt = 0; rdy_idx = -1; mv_idx = -1;
    cut_cnt = 0; stable_err = 0; got_tx = '0;
    @(negedge clk);
    cfg_fsd = 3'(fsd); cfg_loc = LOC_W'(loc); cfg_size = 2'(size);
    cfg_limit24 = lim; cfg_frame_len = POS_W'(flen);
    s_valid = txv; s_data = tx;
    pending = m_valid;
    mv_prev = m_valid;
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      bit_tick = 1'b1;
      frame_start = (i == 0);
      sd_in = ((i >= start) && (i < start + 32)) ? rx[31 - (i - start)] : 1'b1;
      #1;
      if (s_ready) begin rdy_cnt++; rdy_idx = i; end
      @(posedge clk); #1;
      if (sd_oe) begin
        if (oe_cnt == 0) first_oe = i;
        oe_cnt++;
        if ((i >= start) && (i < start + 32)) got_tx[31 - (i - start)] = sd_out;
      end
      if (!mv_prev && m_valid && mv_idx < 0) mv_idx = i;
      mv_prev = m_valid;
      if (slot_cut) cut_cnt++;
      oe_a = sd_oe; out_a = sd_out;
      @(negedge clk);
      bit_tick = 1'b0; frame_start = 1'b0;
      @(posedge clk); #1;
      if ((sd_oe !== oe_a) || (sd_out !== out_a)) stable_err++;
      if (slot_cut) cut_cnt++;
    end
    check((fsd > 5) ? "R2" : "R1", "first enabled bit index", 32'(first_oe), 32'(start));
    check(cut ? "R9" : "R1", "enabled bit count", 32'(oe_cnt), 32'(eff));
    check(lim ? "R5" : "R3", "transmitted word", got_tx, exp_tx);
    check("R3", "output moved without strobe", 32'(stable_err), 32'd0);
    check("R4", "ready count", 32'(rdy_cnt), 32'd1);
    check("R4", "ready index", 32'(rdy_idx), 32'(start));
    check("R9", "cut pulse count", 32'(cut_cnt), cut ? 32'd1 : 32'd0);
    if (!pending) check("R6", "valid rise index", 32'(mv_idx), 32'(last_idx));
    check("R6", "valid after frame", {31'b0, m_valid}, 32'd1);
    check(lim ? "R7" : "R6", "received word", m_data, exp_rx);
    if (ack) begin
      @(negedge clk); m_ready = 1'b1;
      @(posedge clk); #1;
      @(negedge clk); m_ready = 1'b0;
      check("R8", "valid cleared after handshake", {31'b0, m_valid}, 32'd0);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_tick = 1'b0; frame_start = 1'b0; cfg_fsd = '0; cfg_loc = '0;
    cfg_size = 2'd3; cfg_limit24 = 1'b0; cfg_frame_len = POS_W'(64);
    s_valid = 1'b0; s_data = '0; sd_in = 1'b0; m_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R10", "sd_oe in reset", {31'b0, sd_oe}, 32'd0);
    check("R10", "m_valid in reset", {31'b0, m_valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10", "outputs after reset",
          {28'b0, sd_out, sd_oe, m_valid, slot_cut}, 32'd0);

    // R10: strobes before any frame_start open no slot
    begin
      int seen = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk); bit_tick = 1'b1;
        #1; if (s_ready) seen++;
        @(posedge clk); #1; if (sd_oe || m_valid) seen++;
        @(negedge clk); bit_tick = 1'b0;
      end
      check("R10", "activity before first frame", 32'(seen), 32'd0);
    end

    for (int i = 0; i < 8; i++) begin
      vec_t v;
      v = vec_t'(VECS[i]);
      run_frame(int'(v.fsd), int'(v.loc), int'(v.size), v.lim, int'(v.flen),
                v.tx, v.rx, v.txv, 1'b1);
    end

    // R4: no sample offered, slot carries zeros
    run_frame(1, 2, 3, 1'b0, 48, 32'hFFFFFFFF, 32'hA0A0A0A0, 1'b0, 1'b1);

    // R8: unread word is held, then replaced by the next frame's word
    run_frame(0, 5, 1, 1'b0, 32, 32'h11110000, 32'h9ABC0000, 1'b1, 1'b0);
    repeat (5) @(posedge clk);
    #1;
    check("R8", "word held while unaccepted", {31'b0, m_valid}, 32'd1);
    check("R8", "held word unchanged", m_data, 32'h9ABC0000);
    run_frame(0, 5, 1, 1'b0, 32, 32'h22220000, 32'h3C5A0000, 1'b1, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule